// File: doc/BRIEF.md
# Dual-Core Low-Power Sequencer

This block puts two processor cores into low-power states and brings them back out. Each core presents a 2-bit mode select and an idle strobe. The strobe moves the core into the state its select names. In the per-core idle state only that core's clock stops. In the per-core standby state the core waits for a wake event. In the system-wide halt state every clock stops, the PLLs power down and, depending on a keep bit, the watchdog clock and the internal oscillators stop as well.

Two 32-bit select words form one 64-bit mask. The mask chooses which general-purpose pins may wake the system, and a pin requests a wake by going low. Only the first core can ask for halt, and only while the second core sits in idle. Leaving halt takes a timed sequence. The pin must be held low for a qualifying time. Releasing it powers up the PLLs. After a settling count, and once the PLL reports lock, a one-cycle wake interrupt goes to both cores together.

The oscillator domain and the system domain share one clock. An oscillator clock-enable input marks the oscillator ticks, and all qualification and settling counts advance only on those ticks.

Top module: `lowpwr_seq`

## Requirements
- R1: After reset both status outputs read 00 (running), all clock enables are 1, the PLL power request is 1, the oscillator power-down is 0 and both wake interrupts are 0.
- R2: An idle strobe with mode 00 sets that core's status to 01 (idle) and its clock enable to 0 on the following cycle. The system clock enable stays 1.
- R3: A core in idle returns to 00 one cycle after its own interrupt or NMI input is seen. The other core's interrupt has no effect on it.
- R4: An idle strobe with mode 01 sets the status to 10 (standby). Standby ends one cycle after the core's own watchdog interrupt, the peer's NMI, the inter-processor interrupt from the peer, or the core's own power-abort input.
- R5: In standby, a selected pin ends standby only once it has been low for more than the programmed qualification count of oscillator ticks. Pin n is selected by bit n of {select_hi, select_lo}. A pin that is low for exactly the count and then released, or a pin that is not selected, leaves the core in standby.
- R6: A strobe with mode 10 from the first core starts halt only if the second core's status is 01. If it does not start halt, or if the strobe comes from the second core, or if the mode is 11, the strobe is ignored and the status stays 00.
- R7: From the cycle after halt is accepted, both status outputs read 11, the system and core clock enables are 0 and the PLL power request is 0. Core interrupts do not end halt.
- R8: The keep bit is captured when halt is accepted. If it is 1, the watchdog clock stays enabled and the oscillators stay powered. If it is 0, the watchdog clock is off and the oscillator power-down output is 1. Changing the bit during halt has no effect.
- R9: Counting for the halt low qualification starts only after entry has completed. A selected pin must be low for LOW_MIN oscillator ticks while halted. A shorter pulse, a pin that was already low when halt was entered and released shortly after, or an unselected pin, does not start wake-up.
- R10: After a qualified low, the PLL power request rises on the cycle after the pin returns high. Both wake interrupts are then 1 for exactly one cycle, OSC_WAIT+LOCK_DLY cycles later, and both cores then read 00.
- R11: A power-abort from either core ends halt on the next cycle, and so does the first core's watchdog reset if the keep bit was captured as 1. This exit gives no wake interrupt and both cores read 00 afterwards.
- R12: While the PLL lock input is 0, the final settling step is held. The wake interrupt appears one cycle after lock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both domains |
| rst_n | input | 1 | Active-low reset (power-on and external) |
| osc_en | input | 1 | Marks oscillator-clock ticks |
| c0_mode | input | 2 | First core mode select |
| c0_idle_stb | input | 1 | First core idle strobe |
| c0_irq | input | 1 | First core enabled interrupt pending |
| c0_nmi | input | 1 | First core NMI |
| c0_wdint | input | 1 | First core watchdog interrupt |
| c0_pabort | input | 1 | First core power abort |
| c1_mode | input | 2 | Second core mode select |
| c1_idle_stb | input | 1 | Second core idle strobe |
| c1_irq | input | 1 | Second core enabled interrupt pending |
| c1_nmi | input | 1 | Second core NMI |
| c1_wdint | input | 1 | Second core watchdog interrupt |
| c1_pabort | input | 1 | Second core power abort |
| ipi_0to1 | input | 1 | Inter-processor interrupt from first to second core |
| ipi_1to0 | input | 1 | Inter-processor interrupt from second to first core |
| wake_sel_lo | input | SELW | Wake select for pins 0..SELW-1 |
| wake_sel_hi | input | SELW | Wake select for pins SELW..2*SELW-1 |
| wake_pins | input | 2*SELW | General-purpose pin levels, low requests wake |
| qual_cycles | input | QW | Standby pin qualification count |
| wd_keep | input | 1 | Keep watchdog and oscillators alive in halt |
| wdog_rst | input | 1 | First core watchdog reset |
| pll_lock | input | 1 | PLL lock indication |
| c0_clk_en | output | 1 | First core clock enable |
| c1_clk_en | output | 1 | Second core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| intosc_pd | output | 1 | Internal oscillator power-down |
| pll_pwr_req | output | 1 | PLL power-up request |
| c0_wake_irq | output | 1 | Wake interrupt pulse to first core |
| c1_wake_irq | output | 1 | Wake interrupt pulse to second core |
| c0_state | output | 2 | First core status (00 run, 01 idle, 10 standby, 11 halt) |
| c1_state | output | 2 | Second core status |

## Verification
Some rules are checked on every cycle. Halt may begin only when the second core was idle on the cycle before. The second core stays frozen in idle while halt gates the clocks. A core leaves idle or standby only after one of its exit inputs, or a pin, was seen. The keep bit does not move during halt, the settling counter never passes its last value, the PLL request during halt rises only after the pin was released, and the wake pulse never lasts two cycles. The exact cycle counts can only be shown by the bench's scenarios: the standby qualification boundary, the halt low-pulse minimum, the settling delay up to the wake pulse, and the delay added while lock is held off. The same goes for rejected strobes, ignored interrupts in halt and the forced-exit paths.

// File: rtl/lowpwr_pkg.sv
package lowpwr_pkg;

   // Status encoding seen at the ports
   typedef enum logic [1:0] {
      CS_RUN  = 2'b00,
      CS_IDLE = 2'b01,
      CS_STBY = 2'b10,
      CS_HALT = 2'b11
   } core_st_e;

   // Mode select encoding on the core request inputs
   localparam logic [1:0] MODE_IDLE = 2'b00;
   localparam logic [1:0] MODE_STBY = 2'b01;
   localparam logic [1:0] MODE_HALT = 2'b10;

   typedef enum logic [2:0] {
      HS_OFF   = 3'd0,
      HS_ENTER = 3'd1,
      HS_WLOW  = 3'd2,
      HS_WHIGH = 3'd3,
      HS_PLL   = 3'd4,
      HS_WAKE  = 3'd5
   } halt_st_e;

endpackage

// File: rtl/lowpwr_wake_det.sv
module lowpwr_wake_det #(
   parameter int NPINS       = 64,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins,
   input  logic [NPINS-1:0] mask,
   output logic             wake_any
);

   logic [NPINS-1:0] pins_s;

   if (NPINS < 1) begin : g_chk_pins
      $error("lowpwr_wake_det: NPINS must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_chk_sync
      $error("lowpwr_wake_det: SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign pins_s = pins;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][NPINS-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q <= '1;
         end else begin
            pipe_q[0] <= pins;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               pipe_q[i] <= pipe_q[i-1];
            end
         end
      end
      assign pins_s = pipe_q[SYNC_STAGES-1];
   end

   // a selected pin driven low requests a wake
   assign wake_any = |(mask & ~pins_s);

endmodule

// File: rtl/lowpwr_core.sv
module lowpwr_core
   import lowpwr_pkg::*;
#(
   parameter int QW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          osc_en,
   input  logic [1:0]    mode,
   input  logic          idle_stb,
   input  logic          hold,
   input  logic          force_run,
   input  logic          idle_exit,
   input  logic          stby_exit,
   input  logic          wake_any,
   input  logic [QW-1:0] qual_cycles,
   output core_st_e      state,
   output logic          clk_en
);

   localparam logic [QW-1:0] QMAX = '1;

   if (QW < 1) begin : g_chk_qw
      $error("lowpwr_core: QW must be at least 1");
   end

   core_st_e      st_q, st_d;
   logic [QW-1:0] qcnt_q;
   logic          pin_ok;

   assign pin_ok = wake_any && (qcnt_q >= qual_cycles);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CS_RUN: begin
            if (idle_stb) begin
               if (mode == MODE_IDLE)      st_d = CS_IDLE;
               else if (mode == MODE_STBY) st_d = CS_STBY;
            end
         end
         CS_IDLE: if (idle_exit) st_d = CS_RUN;
         CS_STBY: if (stby_exit || pin_ok) st_d = CS_RUN;
         default: st_d = CS_RUN;
      endcase
      if (hold)      st_d = st_q;
      if (force_run) st_d = CS_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_RUN;
         qcnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q != CS_STBY || !wake_any || hold) begin
            qcnt_q <= '0;
         end else if (osc_en && qcnt_q != QMAX) begin
            qcnt_q <= qcnt_q + 1'b1;
         end
      end
   end

   assign state  = st_q;
   assign clk_en = (st_q == CS_RUN);

   AST_IDLE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_RUN && $past(st_q) == CS_IDLE) |-> $past(idle_exit || force_run)); // R3

   AST_STBY_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_RUN && $past(st_q) == CS_STBY) |-> $past(stby_exit || force_run || wake_any)); // R5

endmodule

// File: rtl/lowpwr_halt.sv
module lowpwr_halt
   import lowpwr_pkg::*;
#(
   parameter int LOW_MIN  = 20,
   parameter int OSC_WAIT = 1024,
   parameter int LOCK_DLY = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   input  logic req,
   input  logic wake_any,
   input  logic keep_in,
   input  logic wdog_rst,
   input  logic abort,
   input  logic pll_lock,
   output logic busy,
   output logic gated,
   output logic pll_pd,
   output logic wake,
   output logic exit_run,
   output logic keep_q
);

   localparam int SETTLE = OSC_WAIT + LOCK_DLY;
   localparam int CMAX   = (SETTLE > LOW_MIN) ? SETTLE : LOW_MIN;
   localparam int CW     = $clog2(CMAX + 1);
   localparam logic [CW-1:0] LOW_LAST = CW'(LOW_MIN - 1);
   localparam logic [CW-1:0] SET_LAST = CW'(SETTLE - 1);

   if (LOW_MIN < 1) begin : g_chk_low
      $error("lowpwr_halt: LOW_MIN must be at least 1");
   end
   if (SETTLE < 1) begin : g_chk_settle
      $error("lowpwr_halt: OSC_WAIT + LOCK_DLY must be at least 1");
   end

   halt_st_e      hs_q;
   logic [CW-1:0] cnt_q;
   logic          forced;

   // forced exits apply only while the clocks are gated
   assign forced = gated && (abort || (keep_q && wdog_rst));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q   <= HS_OFF;
         cnt_q  <= '0;
         keep_q <= 1'b0;
      end else if (forced) begin
         hs_q  <= HS_OFF;
         cnt_q <= '0;
      end else begin
         unique case (hs_q)
            HS_OFF: begin
               cnt_q <= '0;
               if (req) begin
                  hs_q   <= HS_ENTER;
                  keep_q <= keep_in;
               end
            end
            HS_ENTER: begin
               cnt_q <= '0;
               hs_q  <= HS_WLOW;
            end
            HS_WLOW: begin
               if (!wake_any) begin
                  cnt_q <= '0;
               end else if (osc_en) begin
                  if (cnt_q == LOW_LAST) begin
                     cnt_q <= '0;
                     hs_q  <= HS_WHIGH;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            HS_WHIGH: begin
               cnt_q <= '0;
               if (!wake_any) hs_q <= HS_PLL;
            end
            HS_PLL: begin
               if (osc_en) begin
                  if (cnt_q == SET_LAST) begin
                     if (pll_lock) hs_q <= HS_WAKE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               cnt_q <= '0;
               hs_q  <= HS_OFF;
            end
         endcase
      end
   end

   assign busy     = (hs_q != HS_OFF);
   assign gated    = busy && (hs_q != HS_WAKE);
   assign pll_pd   = (hs_q == HS_ENTER) || (hs_q == HS_WLOW) || (hs_q == HS_WHIGH);
   assign wake     = (hs_q == HS_WAKE);
   assign exit_run = wake || forced;

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake); // R10

   AST_KEEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(keep_q)); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_q == HS_PLL) |-> (cnt_q <= SET_LAST)); // R10

   AST_PLL_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_q == HS_PLL && $past(hs_q) == HS_WHIGH) |-> $past(!wake_any)); // R9

endmodule

// File: rtl/lowpwr_seq.sv
module lowpwr_seq
   import lowpwr_pkg::*;
#(
   parameter int SELW        = 32,
   parameter int QW          = 8,
   parameter int LOW_MIN     = 20,
   parameter int OSC_WAIT    = 1024,
   parameter int LOCK_DLY    = 64,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic [1:0]        c0_mode,
   input  logic              c0_idle_stb,
   input  logic              c0_irq,
   input  logic              c0_nmi,
   input  logic              c0_wdint,
   input  logic              c0_pabort,
   input  logic [1:0]        c1_mode,
   input  logic              c1_idle_stb,
   input  logic              c1_irq,
   input  logic              c1_nmi,
   input  logic              c1_wdint,
   input  logic              c1_pabort,
   input  logic              ipi_0to1,
   input  logic              ipi_1to0,
   input  logic [SELW-1:0]   wake_sel_lo,
   input  logic [SELW-1:0]   wake_sel_hi,
   input  logic [2*SELW-1:0] wake_pins,
   input  logic [QW-1:0]     qual_cycles,
   input  logic              wd_keep,
   input  logic              wdog_rst,
   input  logic              pll_lock,
   output logic              c0_clk_en,
   output logic              c1_clk_en,
   output logic              sys_clk_en,
   output logic              wdog_clk_en,
   output logic              intosc_pd,
   output logic              pll_pwr_req,
   output logic              c0_wake_irq,
   output logic              c1_wake_irq,
   output logic [1:0]        c0_state,
   output logic [1:0]        c1_state
);

   localparam int NPINS  = 2 * SELW;
   localparam int NCORES = 2;

   if (SELW < 1) begin : g_chk_selw
      $error("lowpwr_seq: SELW must be at least 1");
   end

   logic             wake_any;
   logic             h_busy, h_gated, h_pll_pd, h_wake, h_exit, h_keep;
   logic             halt_req;

   logic [NCORES-1:0][1:0] mode_v;
   logic [NCORES-1:0]      stb_v, irq_v, nmi_v, wdint_v, pab_v, ipi_in_v, cen_v;
   core_st_e               st_v [NCORES];

   assign mode_v   = {c1_mode, c0_mode};
   assign stb_v    = {c1_idle_stb, c0_idle_stb};
   assign irq_v    = {c1_irq, c0_irq};
   assign nmi_v    = {c1_nmi, c0_nmi};
   assign wdint_v  = {c1_wdint, c0_wdint};
   assign pab_v    = {c1_pabort, c0_pabort};
   assign ipi_in_v = {ipi_0to1, ipi_1to0};

   lowpwr_wake_det #(
      .NPINS       (NPINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     (wake_pins),
      .mask     ({wake_sel_hi, wake_sel_lo}),
      .wake_any (wake_any)
   );

   for (genvar g = 0; g < NCORES; g++) begin : g_core
      lowpwr_core #(.QW(QW)) u_core (
         .clk         (clk),
         .rst_n       (rst_n),
         .osc_en      (osc_en),
         .mode        (mode_v[g]),
         .idle_stb    (stb_v[g]),
         .hold        (h_busy),
         .force_run   (h_exit),
         .idle_exit   (irq_v[g] || nmi_v[g]),
         .stby_exit   (wdint_v[g] || nmi_v[g ^ 1] || ipi_in_v[g] || pab_v[g]),
         .wake_any    (wake_any),
         .qual_cycles (qual_cycles),
         .state       (st_v[g]),
         .clk_en      (cen_v[g])
      );
   end

   // system halt: first core only, second core must already be idle
   assign halt_req = c0_idle_stb && (c0_mode == MODE_HALT) && (st_v[0] == CS_RUN)
                     && (st_v[1] == CS_IDLE) && !h_busy;

   lowpwr_halt #(
      .LOW_MIN  (LOW_MIN),
      .OSC_WAIT (OSC_WAIT),
      .LOCK_DLY (LOCK_DLY)
   ) u_halt (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_en   (osc_en),
      .req      (halt_req),
      .wake_any (wake_any),
      .keep_in  (wd_keep),
      .wdog_rst (wdog_rst),
      .abort    (c0_pabort || c1_pabort),
      .pll_lock (pll_lock),
      .busy     (h_busy),
      .gated    (h_gated),
      .pll_pd   (h_pll_pd),
      .wake     (h_wake),
      .exit_run (h_exit),
      .keep_q   (h_keep)
   );

   assign sys_clk_en  = !h_gated;
   assign c0_clk_en   = cen_v[0] && !h_gated;
   assign c1_clk_en   = cen_v[1] && !h_gated;
   assign wdog_clk_en = !h_gated || h_keep;
   assign intosc_pd   = h_gated && !h_keep;
   assign pll_pwr_req = !h_pll_pd;
   assign c0_wake_irq = h_wake;
   assign c1_wake_irq = h_wake;
   assign c0_state    = h_busy ? CS_HALT : st_v[0];
   assign c1_state    = h_busy ? CS_HALT : st_v[1];

   AST_HALT_PEER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h_busy) |-> $past(st_v[1] == CS_IDLE)); // R6

   AST_PEER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      h_gated |-> (st_v[1] == CS_IDLE)); // R7

endmodule

// File: tb/lowpwr_seq_bench.sv
module lowpwr_seq_bench;

   localparam int SELW     = 32;
   localparam int QW       = 8;
   localparam int LOW_MIN  = 5;
   localparam int OSC_WAIT = 40;
   localparam int LOCK_DLY = 8;
   localparam int SETTLE   = OSC_WAIT + LOCK_DLY;
   localparam int PIN      = 37;   // selected wake pin: bit 5 of the high select word
   localparam int UNSEL    = 3;    // never selected

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_en = 1'b1;
   logic [1:0] c0_mode = 2'b00, c1_mode = 2'b00;
   logic c0_idle_stb = 0, c0_irq = 0, c0_nmi = 0, c0_wdint = 0, c0_pabort = 0;
   logic c1_idle_stb = 0, c1_irq = 0, c1_nmi = 0, c1_wdint = 0, c1_pabort = 0;
   logic ipi_0to1 = 0, ipi_1to0 = 0;
   logic [SELW-1:0] wake_sel_lo = '0, wake_sel_hi = '0;
   logic [2*SELW-1:0] wake_pins = '1;
   logic [QW-1:0] qual_cycles = 8'd3;
   logic wd_keep = 0, wdog_rst = 0, pll_lock = 1;
   logic c0_clk_en, c1_clk_en, sys_clk_en, wdog_clk_en, intosc_pd, pll_pwr_req;
   logic c0_wake_irq, c1_wake_irq;
   logic [1:0] c0_state, c1_state;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   lowpwr_seq #(
      .SELW(SELW), .QW(QW), .LOW_MIN(LOW_MIN),
      .OSC_WAIT(OSC_WAIT), .LOCK_DLY(LOCK_DLY), .SYNC_STAGES(0)
   ) u_lowpwr_seq (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
      .c0_mode(c0_mode), .c0_idle_stb(c0_idle_stb), .c0_irq(c0_irq), .c0_nmi(c0_nmi),
      .c0_wdint(c0_wdint), .c0_pabort(c0_pabort),
      .c1_mode(c1_mode), .c1_idle_stb(c1_idle_stb), .c1_irq(c1_irq), .c1_nmi(c1_nmi),
      .c1_wdint(c1_wdint), .c1_pabort(c1_pabort),
      .ipi_0to1(ipi_0to1), .ipi_1to0(ipi_1to0),
      .wake_sel_lo(wake_sel_lo), .wake_sel_hi(wake_sel_hi), .wake_pins(wake_pins),
      .qual_cycles(qual_cycles), .wd_keep(wd_keep), .wdog_rst(wdog_rst), .pll_lock(pll_lock),
      .c0_clk_en(c0_clk_en), .c1_clk_en(c1_clk_en), .sys_clk_en(sys_clk_en),
      .wdog_clk_en(wdog_clk_en), .intosc_pd(intosc_pd), .pll_pwr_req(pll_pwr_req),
      .c0_wake_irq(c0_wake_irq), .c1_wake_irq(c1_wake_irq),
      .c0_state(c0_state), .c1_state(c1_state)
   );

   // advance one edge; inputs change and outputs are read 2 ns after it
   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic check(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic strobe(input int core, input logic [1:0] m);
      if (core == 0) begin c0_mode = m; c0_idle_stb = 1; end
      else           begin c1_mode = m; c1_idle_stb = 1; end
      cyc();
      c0_idle_stb = 0;
      c1_idle_stb = 0;
   endtask

   task automatic enter_halt();
      strobe(1, 2'b00);
      strobe(0, 2'b10);
      check("R7 c0 halt status", c0_state, 3);
      check("R7 c1 halt status", c1_state, 3);
   endtask

   task automatic t_reset();
      check("R1 c0 state", c0_state, 0);
      check("R1 c1 state", c1_state, 0);
      check("R1 clocks", {sys_clk_en, c0_clk_en, c1_clk_en, wdog_clk_en}, 15);
      check("R1 pll req", pll_pwr_req, 1);
      check("R1 osc pd", intosc_pd, 0);
      check("R1 wake", {c0_wake_irq, c1_wake_irq}, 0);
   endtask

   task automatic t_idle();
      strobe(1, 2'b00);
      check("R2 c1 idle", c1_state, 1);
      check("R2 c1 clk off", c1_clk_en, 0);
      check("R2 sys clk on", sys_clk_en, 1);
      check("R2 c0 untouched", c0_state, 0);
      c0_irq = 1; cyc(); c0_irq = 0;
      check("R3 peer irq ignored", c1_state, 1);
      c1_nmi = 1; cyc(); c1_nmi = 0;
      check("R3 nmi exit", c1_state, 0);
      strobe(0, 2'b00);
      c0_irq = 1; cyc(); c0_irq = 0;
      check("R3 irq exit", c0_state, 0);
   endtask

   task automatic t_stby_src(input int src);
      strobe(0, 2'b01);
      check("R4 c0 standby", c0_state, 2);
      check("R4 c0 clk off", c0_clk_en, 0);
      case (src)
         0: c0_wdint = 1;
         1: c1_nmi = 1;
         2: ipi_1to0 = 1;
         default: c0_pabort = 1;
      endcase
      cyc();
      c0_wdint = 0; c1_nmi = 0; ipi_1to0 = 0; c0_pabort = 0;
      check("R4 standby exit source", c0_state, 0);
   endtask

   task automatic t_stby_pin();
      wake_sel_hi = 32'h1 << (PIN - SELW);
      qual_cycles = 8'd3;
      strobe(0, 2'b01);
      wake_pins[UNSEL] = 0; cyc(10); wake_pins[UNSEL] = 1;
      check("R5 unselected pin", c0_state, 2);
      wake_pins[PIN] = 0; cyc(3); wake_pins[PIN] = 1; cyc();
      check("R5 exact count kept", c0_state, 2);
      wake_pins[PIN] = 0; cyc(3);
      check("R5 not yet", c0_state, 2);
      cyc();
      wake_pins[PIN] = 1;
      check("R5 qualified exit", c0_state, 0);
   endtask

   task automatic t_reject();
      strobe(0, 2'b10);
      check("R6 halt needs idle peer", c0_state, 0);
      check("R6 sys clk", sys_clk_en, 1);
      strobe(0, 2'b11);
      check("R6 mode 11 ignored", c0_state, 0);
      strobe(1, 2'b10);
      check("R6 peer halt ignored", c1_state, 0);
      check("R6 pll req", pll_pwr_req, 1);
   endtask

   task automatic t_halt_full();
      wd_keep = 0;
      strobe(1, 2'b00);
      wake_pins[PIN] = 0;          // already low when halt is entered
      strobe(0, 2'b10);
      check("R7 sys clk off", sys_clk_en, 0);
      check("R7 core clks off", {c0_clk_en, c1_clk_en}, 0);
      check("R7 pll off", pll_pwr_req, 0);
      check("R8 osc pd", intosc_pd, 1);
      check("R8 wdog off", wdog_clk_en, 0);
      cyc(2);
      wake_pins[PIN] = 1;
      cyc(2);
      check("R9 early low no wake", pll_pwr_req, 0);
      wd_keep = 1; cyc();
      check("R8 keep latched", intosc_pd, 1);
      wd_keep = 0;
      c1_irq = 1; c0_irq = 1; cyc(); c1_irq = 0; c0_irq = 0;
      check("R7 irq ignored", c1_state, 3);
      wake_pins[PIN] = 0; cyc(LOW_MIN - 1); wake_pins[PIN] = 1; cyc(2);
      check("R9 short pulse", pll_pwr_req, 0);
      wake_pins[UNSEL] = 0; cyc(12); wake_pins[UNSEL] = 1; cyc();
      check("R9 unselected", pll_pwr_req, 0);
      wake_pins[PIN] = 0; cyc(LOW_MIN);
      check("R9 held low pll off", pll_pwr_req, 0);
      wake_pins[PIN] = 1; cyc();
      check("R10 pll request", pll_pwr_req, 1);
      check("R10 still halted", c0_state, 3);
      cyc(SETTLE - 1);
      check("R10 wake not early", c0_wake_irq, 0);
      cyc();
      check("R10 wake both", {c0_wake_irq, c1_wake_irq}, 3);
      cyc();
      check("R10 wake one cycle", {c0_wake_irq, c1_wake_irq}, 0);
      check("R10 both run", {c0_state, c1_state}, 0);
      check("R10 clocks on", {sys_clk_en, c0_clk_en, c1_clk_en}, 7);
   endtask

   task automatic t_lock();
      enter_halt();
      cyc();
      wake_pins[PIN] = 0; cyc(LOW_MIN);
      pll_lock = 0;
      wake_pins[PIN] = 1; cyc(SETTLE + 5);
      check("R12 held without lock", c0_wake_irq, 0);
      check("R12 still halted", c1_state, 3);
      pll_lock = 1; cyc();
      check("R12 wake after lock", c0_wake_irq, 1);
      cyc();
   endtask

   task automatic t_forced();
      wd_keep = 1;
      enter_halt();
      check("R8 wdog kept", wdog_clk_en, 1);
      check("R8 osc kept", intosc_pd, 0);
      wdog_rst = 1; cyc(); wdog_rst = 0;
      check("R11 wdog reset exit", {c0_state, c1_state}, 0);
      check("R11 no wake", c0_wake_irq, 0);
      wd_keep = 0;
      enter_halt();
      wdog_rst = 1; cyc(); wdog_rst = 0;
      check("R11 wdog reset ignored", c0_state, 3);
      c1_pabort = 1; cyc(); c1_pabort = 0;
      check("R11 abort exit", {c0_state, c1_state}, 0);
      check("R11 abort no wake", c1_wake_irq, 0);
      enter_halt();
      c0_pabort = 1; cyc(); c0_pabort = 0;
      check("R11 c0 abort exit", c0_state, 0);
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1;
      cyc();
      t_idle();
      for (int s = 0; s < 4; s++) t_stby_src(s);
      t_stby_pin();
      t_reject();
      t_halt_full();
      t_lock();
      t_forced();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule